// File: doc/BRIEF.md
# Address-Opcode Fixed-Point Coprocessor

This block is a small arithmetic engine that sits on a plain synchronous host bus. It holds eight 32-bit registers, each a signed Q16.16 fixed-point value. It has no command register. Instead, the bus address picks both the operation and the target register. A host write can load a register, add to it, subtract from it or multiply it, and each of these costs exactly one ordinary bus write. A host read returns a register value. The block needs nothing from the host except normal reads and writes, so it works with any processor that can drive the bus.

Address decoding works on the low five bits. Bits [2:0] select the register. Bits [4:3] select the operation: 0 loads, 1 adds, 2 subtracts and 3 multiplies. Any address with a nonzero bit above bit 4 is outside the block's window. Every write takes effect at the clock edge on which it is presented. The read data path is combinational from the register file, so a read in the next cycle already returns the updated value.

Top module: `addrop_coproc`

## Requirements
- R1: While `rst_n` is low, all eight registers are cleared to zero at each rising clock edge.
- R2: A write to address 0..7 stores `wdata` unchanged into register `addr`. A read in the following cycle returns that value.
- R3: With `rd_en` high and `addr` in 0..31, `rdata` shows register (`addr` mod 8) in the same cycle. With `rd_en` low, `rdata` is zero.
- R4: A write to address 8..15 replaces register (`addr`−8) with the saturated sum of that register and `wdata`.
- R5: A write to address 16..23 replaces register (`addr`−16) with the saturated difference, register minus `wdata`.
- R6: A write to address 24..31 replaces register (`addr`−24) with the product of the register and `wdata`, both read as Q16.16. The full 64-bit product is shifted right arithmetically by 16 (rounding toward minus infinity) and then saturated.
- R7: For addresses 32 and above, a read returns zero and a write changes no register.
- R8: A write changes only the one register its address selects.
- R9: When a read and a write are presented in the same cycle, `rdata` shows the value the register held before that write.
- R10: Saturation clamps positive overflow to 0x7FFFFFFF and negative overflow to 0x80000000. It never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Bus address; the low bits carry the opcode and the register number |
| wdata | input | 32 | Write operand, Q16.16 two's complement |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data, zero when no read is active or the address is out of window |

## Verification
On every cycle, the assertions check the following:
- Only the selected register may change.
- A load lands unchanged.
- Reset clears the file.
- A read outside the window yields zero.
- Data written to a register reads back on the next cycle.
- Add and subtract never flip sign on overflow.
- Multiply yields a non-negative result for operands of the same sign.

The exact saturated values, the direction of truncation for small negative products, the aliasing of operation addresses onto reads, and read-before-write ordering can only be shown by the bench's scenarios. There, a behavioural model predicts `rdata` cycle by cycle.

// File: rtl/addrop_pkg.sv
package addrop_pkg;

  localparam int WORD_W = 32;
  localparam int FRAC_W = 16;

  typedef logic signed [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2,
    OP_MUL  = 2'd3
  } op_e;

  localparam word_t WORD_MAX = {1'b0, {(WORD_W-1){1'b1}}};
  localparam word_t WORD_MIN = {1'b1, {(WORD_W-1){1'b0}}};

  // saturating sum: one guard bit exposes overflow
  function automatic word_t sat_add(input word_t a, input word_t b);
    logic signed [WORD_W:0] s;
    s = {a[WORD_W-1], a} + {b[WORD_W-1], b};
    if (s[WORD_W] != s[WORD_W-1]) return s[WORD_W] ? WORD_MIN : WORD_MAX;
    return s[WORD_W-1:0];
  endfunction

  function automatic word_t sat_sub(input word_t a, input word_t b);
    logic signed [WORD_W:0] s;
    s = {a[WORD_W-1], a} - {b[WORD_W-1], b};
    if (s[WORD_W] != s[WORD_W-1]) return s[WORD_W] ? WORD_MIN : WORD_MAX;
    return s[WORD_W-1:0];
  endfunction

  // Q-format product: full width, arithmetic shift, clamp to word range
  function automatic word_t fx_mul(input word_t a, input word_t b);
    logic signed [2*WORD_W-1:0] ea, eb, p, sh;
    logic signed [2*WORD_W-1:0] hi_lim, lo_lim;
    ea = {{WORD_W{a[WORD_W-1]}}, a};
    eb = {{WORD_W{b[WORD_W-1]}}, b};
    p  = ea * eb;
    sh = p >>> FRAC_W;
    hi_lim = {{(WORD_W+1){1'b0}}, {(WORD_W-1){1'b1}}};
    lo_lim = {{(WORD_W+1){1'b1}}, {(WORD_W-1){1'b0}}};
    if (sh > hi_lim) return WORD_MAX;
    if (sh < lo_lim) return WORD_MIN;
    return sh[WORD_W-1:0];
  endfunction

endpackage

// File: rtl/addrop_decode.sv
module addrop_decode
  import addrop_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NREG   = 8,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output logic              in_range,
  output op_e               op,
  output logic [SEL_W-1:0]  sel,
  output logic [NREG-1:0]   we_vec
);

  // bits above the opcode field must be zero for the window to match
  assign in_range = (addr[ADDR_W-1:SEL_W+2] == '0);
  assign sel      = addr[SEL_W-1:0];
  assign op       = op_e'(addr[SEL_W+1:SEL_W]);

  for (genvar i = 0; i < NREG; i++) begin : g_we
    assign we_vec[i] = wr_en && in_range && (sel == SEL_W'(i));
  end

endmodule

// File: rtl/addrop_alu.sv
module addrop_alu
  import addrop_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  active,
  input  op_e   op,
  input  word_t cur,
  input  word_t operand,
  output word_t result
);

  always_comb begin
    unique case (op)
      OP_LOAD: result = operand;
      OP_ADD:  result = sat_add(cur, operand);
      OP_SUB:  result = sat_sub(cur, operand);
      OP_MUL:  result = fx_mul(cur, operand);
      default: result = operand;
    endcase
  end

  AST_ADD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && op == OP_ADD && cur[WORD_W-1] == operand[WORD_W-1])
      |-> (result[WORD_W-1] == cur[WORD_W-1]));  // R4
  AST_SUB_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && op == OP_SUB && cur[WORD_W-1] != operand[WORD_W-1])
      |-> (result[WORD_W-1] == cur[WORD_W-1]));  // R5
  AST_MUL_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (active && op == OP_MUL && cur[WORD_W-1] == operand[WORD_W-1])
      |-> !result[WORD_W-1]);  // R6

endmodule

// File: rtl/addrop_regfile.sv
module addrop_regfile
  import addrop_pkg::*;
#(
  parameter int NREG   = 8,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREG-1:0]  we_vec,
  input  word_t            wval,
  input  logic [SEL_W-1:0] rd_sel,
  output word_t            rd_val
);

  word_t mem [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) if (we_vec[i]) mem[i] <= wval;
    end
  end

  assign rd_val = mem[rd_sel];

  for (genvar i = 0; i < NREG; i++) begin : g_chk
    AST_HOLD_UNTARGETED: assert property (@(posedge clk) disable iff (!rst_n)
      !we_vec[i] |=> $stable(mem[i]));  // R8
    AST_TARGET_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      we_vec[i] |=> (mem[i] == $past(wval)));  // R2
    AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |=> (mem[i] == '0));  // R1
  end

endmodule

// File: rtl/addrop_coproc.sv
module addrop_coproc
  import addrop_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NREG   = 8,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [31:0]       rdata
);

  logic             in_range;
  op_e              op;
  logic [SEL_W-1:0] sel;
  logic [NREG-1:0]  we_vec;
  word_t            cur_val;
  word_t            new_val;
  logic             write_hit;

  addrop_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
    .addr     (addr),
    .wr_en    (wr_en),
    .in_range (in_range),
    .op       (op),
    .sel      (sel),
    .we_vec   (we_vec)
  );

  assign write_hit = wr_en && in_range;

  addrop_alu u_alu (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (write_hit),
    .op      (op),
    .cur     (cur_val),
    .operand (word_t'(wdata)),
    .result  (new_val)
  );

  addrop_regfile #(.NREG(NREG)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_vec (we_vec),
    .wval   (new_val),
    .rd_sel (sel),
    .rd_val (cur_val)
  );

  assign rdata = (rd_en && in_range) ? cur_val : '0;

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !in_range) |-> (rdata == '0));  // R7
  AST_READ_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(write_hit) && $past(op) == OP_LOAD && rd_en
      && addr == $past(addr)) |-> (rdata == $past(wdata)));  // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0));  // R3

endmodule

// File: tb/addrop_coproc_test.sv
module addrop_coproc_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;

  int compared = 0;
  int mismatched = 0;
  longint model [8];

  always #2 clk = ~clk;

  addrop_coproc uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata)
  );

  localparam longint QMAX = 64'sd2147483647;
  localparam longint QMIN = -64'sd2147483648;

  function automatic longint clampv(input longint v);
    if (v > QMAX) return QMAX;
    if (v < QMIN) return QMIN;
    return v;
  endfunction

  function automatic longint qmul(input longint a, input longint b);
    longint p, q;
    p = a * b;
    q = p / 65536;
    if (p < 0 && q * 65536 != p) q = q - 1;  // floor toward minus infinity
    return clampv(q);
  endfunction

  task automatic step(input int a, input longint d, input bit we, input bit re,
                      input string tag);
    longint exp_v;
    @(negedge clk);
    addr  = a[7:0];
    wdata = d[31:0];
    wr_en = we;
    rd_en = re;
    #1;
    exp_v = (re && a < 32) ? model[a % 8] : 0;
    compared++;
    if (rdata !== exp_v[31:0]) begin
      mismatched++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rdata, exp_v[31:0]);
    end
    @(posedge clk);
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) model[i] = 0;
    end else if (we && a < 32) begin
      case (a / 8)
        0: model[a % 8] = d;
        1: model[a % 8] = clampv(model[a % 8] + d);
        2: model[a % 8] = clampv(model[a % 8] - d);
        default: model[a % 8] = qmul(model[a % 8], d);
      endcase
    end
  endtask

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 0;
    step(3, 64'sh1234, 1, 0, "R1");
    step(0, 0, 0, 0, "R1");
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 8; i++) step(i, 0, 0, 1, "R1");
    // R2 direct loads, read back
    for (int i = 0; i < 8; i++) step(i, longint'(i) * 65536 + 7, 1, 0, "R2");
    for (int i = 0; i < 8; i++) step(i, 0, 0, 1, "R2");
    step(2, 0, 0, 0, "R3");
    // R3 aliases of operation addresses onto reads
    step(13, 0, 0, 1, "R3");
    step(22, 0, 0, 1, "R3");
    step(31, 0, 0, 1, "R3");
    // R4 add, plain and saturating (R10)
    step(9, 64'sh00018000, 1, 1, "R4");
    step(1, 0, 0, 1, "R4");
    step(0, 64'sh7FFF0000, 1, 1, "R10");
    step(8, 64'sh7FFF0000, 1, 1, "R10");
    step(0, 0, 0, 1, "R10");
    step(1, QMIN, 1, 1, "R10");
    step(9, -64'sh40000000, 1, 1, "R10");
    step(1, 0, 0, 1, "R10");
    // R5 subtract, plain and saturating
    step(2, 64'sh00050000, 1, 1, "R5");
    step(18, 64'sh00018000, 1, 1, "R5");
    step(2, 0, 0, 1, "R5");
    step(19, -64'sh7FFFFFFF, 1, 1, "R5");
    step(3, 0, 0, 1, "R5");
    step(20, 64'sh7FFFFFFF, 1, 1, "R5");
    step(20, 64'sh7FFFFFFF, 1, 1, "R5");
    step(4, 0, 0, 1, "R5");
    // R6 multiply: positive, negative, floor of tiny negative, overflow
    step(5, 64'sh00018000, 1, 1, "R6");
    step(29, 64'sh00020000, 1, 1, "R6");
    step(5, 0, 0, 1, "R6");
    step(29, -64'sh00008000, 1, 1, "R6");
    step(5, 0, 0, 1, "R6");
    step(6, -1, 1, 1, "R6");
    step(30, 64'sh00008000, 1, 1, "R6");
    step(6, 0, 0, 1, "R6");
    step(7, 64'sh01000000, 1, 1, "R6");
    step(31, 64'sh01000000, 1, 1, "R6");
    step(7, 0, 0, 1, "R6");
    step(7, 64'sh01000000, 1, 1, "R6");
    step(31, -64'sh01000000, 1, 1, "R6");
    step(7, 0, 0, 1, "R6");
    // R7 out-of-window reads and writes
    step(32, 64'sh55555555, 1, 1, "R7");
    step(40, 64'sh11110000, 1, 1, "R7");
    step(255, 64'sh22220000, 1, 1, "R7");
    step(64, 0, 0, 1, "R7");
    for (int i = 0; i < 8; i++) step(i, 0, 0, 1, "R7");
    // R8 one op leaves neighbours alone
    step(11, 64'sh00010000, 1, 1, "R8");
    for (int i = 0; i < 8; i++) step(i, 0, 0, 1, "R8");
    // R9 simultaneous read and write shows old value
    step(4, 64'sh0ABC0000, 1, 1, "R9");
    step(12, 64'sh00010000, 1, 1, "R9");
    step(4, 0, 0, 1, "R9");
    // R1 reset again clears everything
    @(negedge clk); rst_n = 1'b0;
    step(0, 0, 0, 0, "R1");
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 8; i++) step(i, 0, 0, 1, "R1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule